// File: doc/BRIEF.md
# Single-Cycle Integer RISC Core

This block is a 32-bit processor that completes one instruction per clock. It covers a small integer subset: register add, AND, OR and signed compare, an add with a 16-bit immediate, two conditional branches and an absolute jump. The core holds a program counter, a 32-entry register file, an ALU, an instruction decoder and a next-PC multiplexer. It executes out of an internal instruction array.

The instruction array is filled through a word-wide load port, normally while reset is held. After reset is released the core fetches from address 0. An observation port shows, for the instruction now at the PC, whether it will write a register, which register, and the value. A testbench can compare that stream, and the PC, against a reference model on every clock.

Top module: `core_top`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and wb_en_o is 0. Reset clears every register to 0, and the first instruction after release is fetched from address 0.
- R2: An instruction with opcode 0x00, shift field 0 and function 0x20 writes rs + rt, modulo 2^32, into register rd. The field positions are op[31:26], rs[25:21], rt[20:16], rd[15:11], shift[10:6] and function[5:0].
- R3: Opcode 0x00 with function 0x24 writes rs AND rt into rd. Function 0x25 writes rs OR rt into rd.
- R4: Opcode 0x00 with function 0x2A writes 1 into rd when rs is less than rt as signed two's complement values, and 0 otherwise.
- R5: Opcode 0x08 writes rs plus the sign-extended immediate[15:0] into register rt.
- R6: Opcode 0x04 sets the next PC to PC+4+(sign-extended immediate << 2) when rs equals rt, and to PC+4 otherwise. It writes no register.
- R7: Opcode 0x05 takes the same target when rs differs from rt, and goes to PC+4 otherwise. It writes no register.
- R8: Opcode 0x02 sets the next PC to {PC+4 bits [31:28], index[25:0], 2'b00}. It writes no register.
- R9: Register 0 always reads as 0. An instruction whose destination is register 0 leaves wb_en_o low and changes no register.
- R10: Any other opcode, or opcode 0x00 with another function value or a nonzero shift field, writes no register and advances the PC by 4.
- R11: wb_en_o, wb_idx_o and wb_data_o describe the register write of the instruction currently at pc_o. That write commits at the next rising edge of clk_i.
- R12: A rising edge of clk_i with imem_we_i high stores imem_wdata_i at word imem_waddr_i. Instructions are fetched from word pc_o[IMEM_AW+1:2], so the PC wraps modulo the array size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_we_i | input | 1 | Instruction array write strobe |
| imem_waddr_i | input | IMEM_AW | Instruction array word address |
| imem_wdata_i | input | 32 | Instruction word to store |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | The current instruction writes a register |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value to be written |

## Verification
The assertions assume that the instruction array is fully written before reset is released, so no fetch returns an unknown word. They also assume that the load port is idle while the core runs. The stimulus loads every word of the array during reset, including the unused words, which are filled with an unrecognised encoding. It never strobes the load port afterwards. The random programs use only register indices and small branch offsets, and any PC that leaves the array wraps back to a defined word.

// File: rtl/core_pkg.sv
`timescale 1ns/1ps
package core_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
  typedef enum logic [1:0] {NPC_SEQ, NPC_BEQ, NPC_BNE, NPC_JMP} npc_sel_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_is_rt;
    logic     b_is_imm;
    alu_op_e  alu_op;
    npc_sel_e npc_sel;
  } ctrl_t;
endpackage

// File: rtl/core_decoder.sv
`timescale 1ns/1ps
module core_decoder
  import core_pkg::*;
(
  input  logic [5:0]  opcode_i,
  input  logic [10:0] func_i,   // shift[10:6], function[5:0]
  output ctrl_t       ctrl_o
);
  logic [4:0] shamt;
  logic [5:0] funct;
  assign shamt = func_i[10:6];
  assign funct = func_i[5:0];

  always_comb begin
    ctrl_o = '0;
    unique case (opcode_i)
      OP_RTYPE: begin
        if (shamt == '0) begin
          unique case (funct)
            FN_ADD: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
            FN_AND: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_AND; end
            FN_OR:  begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_OR;  end
            FN_SLT: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_SLT; end
            default: ;
          endcase
        end
      end
      OP_ADDI: begin
        ctrl_o.reg_we    = 1'b1;
        ctrl_o.dst_is_rt = 1'b1;
        ctrl_o.b_is_imm  = 1'b1;
        ctrl_o.alu_op    = ALU_ADD;
      end
      OP_BEQ:  ctrl_o.npc_sel = NPC_BEQ;
      OP_BNE:  ctrl_o.npc_sel = NPC_BNE;
      OP_J:    ctrl_o.npc_sel = NPC_JMP;
      default: ;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
`timescale 1ns/1ps
module core_alu
  import core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
`timescale 1ns/1ps
module core_regfile #(
  parameter int W  = 32,
  parameter int N  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [N-1:0][W-1:0] bank;

  // entry 0 is hard-wired zero
  assign bank[0] = '0;

  for (genvar g = 1; g < N; g++) begin : g_ent
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (we_i && waddr_i == AW'(g))    q <= wdata_i;
    end
    assign bank[g] = q;
  end

  assign rdata_a_o = bank[raddr_a_i];
  assign rdata_b_o = bank[raddr_b_i];
endmodule

// File: rtl/core_imem.sv
`timescale 1ns/1ps
module core_imem #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/core_top.sv
`timescale 1ns/1ps
module core_top
  import core_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int IMEM_AW    = $clog2(IMEM_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               imem_we_i,
  input  logic [IMEM_AW-1:0] imem_waddr_i,
  input  logic [XLEN-1:0]    imem_wdata_i,
  output logic [XLEN-1:0]    pc_o,
  output logic               wb_en_o,
  output logic [RIDX_W-1:0]  wb_idx_o,
  output logic [XLEN-1:0]    wb_data_o
);
  logic [XLEN-1:0]   pc_q, pc_nxt, pc_plus4, br_tgt, jmp_tgt;
  logic [XLEN-1:0]   instr, rs_data, rt_data, imm_sext, alu_b, alu_y;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
  logic              rs_eq_rt, take_br, wr_en;
  ctrl_t             ctrl;

  // fetch
  core_imem #(.W(XLEN), .DEPTH(IMEM_DEPTH), .AW(IMEM_AW)) u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_waddr_i),
    .wdata_i (imem_wdata_i),
    .raddr_i (pc_q[IMEM_AW+1:2]),
    .rdata_o (instr)
  );

  assign rs_idx   = instr[25:21];
  assign rt_idx   = instr[20:16];
  assign rd_idx   = instr[15:11];
  assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  core_decoder u_dec (
    .opcode_i (instr[31:26]),
    .func_i   (instr[10:0]),
    .ctrl_o   (ctrl)
  );

  core_regfile #(.W(XLEN), .N(NREG), .AW(RIDX_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en),
    .waddr_i   (dst_idx),
    .wdata_i   (alu_y),
    .raddr_a_i (rs_idx),
    .raddr_b_i (rt_idx),
    .rdata_a_o (rs_data),
    .rdata_b_o (rt_data)
  );

  assign alu_b = ctrl.b_is_imm ? imm_sext : rt_data;

  core_alu #(.W(XLEN)) u_alu (
    .a_i  (rs_data),
    .b_i  (alu_b),
    .op_i (ctrl.alu_op),
    .y_o  (alu_y)
  );

  assign dst_idx = ctrl.dst_is_rt ? rt_idx : rd_idx;
  // writes to entry 0 dropped here so the observation port matches state
  assign wr_en   = ctrl.reg_we && (dst_idx != '0) && rst_ni;

  // next pc
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
  assign rs_eq_rt = (rs_data == rt_data);

  always_comb begin
    take_br = 1'b0;
    unique case (ctrl.npc_sel)
      NPC_BEQ: take_br = rs_eq_rt;
      NPC_BNE: take_br = !rs_eq_rt;
      default: take_br = 1'b0;
    endcase
  end

  always_comb begin
    if (ctrl.npc_sel == NPC_JMP) pc_nxt = jmp_tgt;
    else if (take_br)            pc_nxt = br_tgt;
    else                         pc_nxt = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nxt;
  end

  assign pc_o      = pc_q;
  assign wb_en_o   = wr_en;
  assign wb_idx_o  = dst_idx;
  assign wb_data_o = alu_y;
endmodule

// File: rtl/core_checker.sv
`timescale 1ns/1ps
module core_checker
  import core_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input logic [31:0] rs_data_i,
  input logic [31:0] rt_data_i,
  input logic        wb_en_i,
  input logic [4:0]  wb_idx_i,
  input logic [31:0] wb_data_i
);
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, shamt;
  logic [31:0] simm, pc4, br_tgt, jmp_tgt;
  logic        r_ok, known;

  assign op      = instr_i[31:26];
  assign rs      = instr_i[25:21];
  assign rt      = instr_i[20:16];
  assign rd      = instr_i[15:11];
  assign shamt   = instr_i[10:6];
  assign funct   = instr_i[5:0];
  assign simm    = {{16{instr_i[15]}}, instr_i[15:0]};
  assign pc4     = pc_i + 32'd4;
  assign br_tgt  = pc4 + (simm << 2);
  assign jmp_tgt = {pc4[31:28], instr_i[25:0], 2'b00};
  assign r_ok    = (op == OP_RTYPE) && (shamt == 5'd0) &&
                   (funct == FN_ADD || funct == FN_AND || funct == FN_OR || funct == FN_SLT);
  assign known   = r_ok || op == OP_ADDI || op == OP_BEQ || op == OP_BNE || op == OP_J;

  a_r1_pc_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> pc_i == 32'd0);

  a_r2_add_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_ok && funct == FN_ADD && rd != 5'd0) |-> (wb_en_i && wb_data_i == rs_data_i + rt_data_i));

  a_r4_slt_bool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_ok && funct == FN_SLT && rd != 5'd0) |->
      (wb_data_i == {31'd0, $signed(rs_data_i) < $signed(rt_data_i)}));

  a_r5_addi_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ADDI && rt != 5'd0) |-> (wb_en_i && wb_idx_i == rt && wb_data_i == rs_data_i + simm));

  a_r6_beq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && rs_data_i == rt_data_i) |=> pc_i == $past(br_tgt));

  a_r6_beq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && rs_data_i != rt_data_i) |=> pc_i == $past(pc4));

  a_r7_bne_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BNE && rs_data_i != rt_data_i) |=> pc_i == $past(br_tgt));

  a_r8_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_J) |=> pc_i == $past(jmp_tgt));

  a_r9_r0_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs == 5'd0) |-> rs_data_i == 32'd0);

  a_r9_no_r0_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_i |-> wb_idx_i != 5'd0);

  a_r10_unknown_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> !wb_en_i);

  a_r10_unknown_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |=> pc_i == $past(pc4));
endmodule

bind core_top core_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_i      (pc_o),
  .instr_i   (instr),
  .rs_data_i (rs_data),
  .rt_data_i (rt_data),
  .wb_en_i   (wb_en_o),
  .wb_idx_i  (wb_idx_o),
  .wb_data_i (wb_data_o)
);

// File: tb/core_top_tb_top.sv
`timescale 1ns/1ps
module core_top_tb_top;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int WD_CYCLES = 150000;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          imem_we_i;
  logic [AW-1:0] imem_waddr_i;
  logic [31:0]   imem_wdata_i;
  logic [31:0]   pc_o;
  logic          wb_en_o;
  logic [4:0]    wb_idx_o;
  logic [31:0]   wb_data_o;

  always #2 clk_i = ~clk_i;

  core_top #(.IMEM_DEPTH(DEPTH)) dut_i (
    .clk_i, .rst_ni, .imem_we_i, .imem_waddr_i, .imem_wdata_i,
    .pc_o, .wb_en_o, .wb_idx_o, .wb_data_o
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  logic [31:0] prog  [DEPTH];
  logic [31:0] m_mem [DEPTH];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc;
  bit   [31:0] seed;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pc=%08h actual=%08h expected=%08h", tag, m_pc, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int idx);
    return {6'h02, idx[25:0]};
  endfunction

  function automatic bit [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // behavioural model of one instruction at m_pc
  task automatic model_eval(output logic we, output logic [4:0] idx, output logic [31:0] data,
                            output logic [31:0] npc, output string tag);
    logic [31:0] ins, a, b, simm, p4;
    ins  = m_mem[(m_pc >> 2) % DEPTH];
    a    = m_reg[ins[25:21]];
    b    = m_reg[ins[20:16]];
    simm = {{16{ins[15]}}, ins[15:0]};
    p4   = m_pc + 4;
    we = 0; idx = 0; data = 0; npc = p4; tag = "R10";
    case (ins[31:26])
      6'h00: if (ins[10:6] == 0) begin
        case (ins[5:0])
          6'h20: begin we = 1; data = a + b; tag = "R2"; end
          6'h24: begin we = 1; data = a & b; tag = "R3"; end
          6'h25: begin we = 1; data = a | b; tag = "R3"; end
          6'h2A: begin we = 1; data = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
          default: ;
        endcase
        idx = ins[15:11];
      end
      6'h08: begin we = 1; idx = ins[20:16]; data = a + simm; tag = "R5"; end
      6'h04: begin tag = "R6"; if (a == b) npc = p4 + (simm << 2); end
      6'h05: begin tag = "R7"; if (a != b) npc = p4 + (simm << 2); end
      6'h02: begin tag = "R8"; npc = {p4[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (we && idx == 0) begin we = 0; tag = "R9"; end
  endtask

  // R12: fill the whole array through the load port while reset is held
  task automatic load_prog();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk_i);
      imem_we_i    = 1'b1;
      imem_waddr_i = AW'(i);
      imem_wdata_i = prog[i];
      m_mem[i]     = prog[i];
    end
    @(negedge clk_i);
    imem_we_i = 1'b0;
  endtask

  task automatic run_prog(input int ncyc);
    logic        we;
    logic [4:0]  idx;
    logic [31:0] data, npc;
    string       tag, prev_tag;
    @(negedge clk_i);
    rst_ni = 1'b0;
    load_prog();
    #1;
    check("R1 reset pc", pc_o, 32'd0);
    check("R1 reset wb_en", {31'd0, wb_en_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_pc = 0;
    for (int r = 0; r < 32; r++) m_reg[r] = 32'd0;
    prev_tag = "R1";
    for (int c = 0; c < ncyc; c++) begin
      #1;
      check({prev_tag, " R12 pc"}, pc_o, m_pc);
      model_eval(we, idx, data, npc, tag);
      check({tag, " R11 wb_en"}, {31'd0, wb_en_o}, {31'd0, we});
      if (we) begin
        check({tag, " R11 wb_idx"}, {27'd0, wb_idx_o}, {27'd0, idx});
        check({tag, " R11 wb_data"}, wb_data_o, data);
        m_reg[idx] = data;
      end
      m_pc = npc;
      prev_tag = tag;
      @(negedge clk_i);
    end
  endtask

  task automatic build_directed();
    for (int i = 0; i < DEPTH; i++) prog[i] = 32'h0000_0000;   // unrecognised filler
    prog[0]  = enc_i(6'h08, 0, 1, 5);          // r1 = 5
    prog[1]  = enc_i(6'h08, 0, 2, -3);         // r2 = -3
    prog[2]  = enc_r(1, 2, 3, 6'h20);          // R2 r3 = 2
    prog[3]  = enc_r(1, 2, 4, 6'h24);          // R3 and
    prog[4]  = enc_r(1, 2, 5, 6'h25);          // R3 or
    prog[5]  = enc_r(2, 1, 6, 6'h2A);          // R4 signed: 1
    prog[6]  = enc_r(1, 2, 7, 6'h2A);          // R4: 0
    prog[7]  = enc_i(6'h08, 1, 0, 7);          // R9 write to r0 dropped
    prog[8]  = enc_r(0, 1, 8, 6'h20);          // R9 r0 reads 0 -> 5
    prog[9]  = enc_i(6'h04, 1, 1, 1);          // R6 taken, skip 10
    prog[10] = enc_i(6'h08, 0, 9, 99);
    prog[11] = enc_i(6'h05, 1, 1, 5);          // R7 not taken
    prog[12] = enc_i(6'h05, 1, 2, 1);          // R7 taken, skip 13
    prog[13] = enc_i(6'h08, 0, 9, 77);
    prog[14] = enc_i(6'h04, 1, 2, 3);          // R6 not taken
    prog[15] = 32'hFC00_0000;                  // R10 unknown opcode
    prog[16] = enc_r(1, 2, 10, 6'h22);         // R10 unknown function
    prog[17] = enc_r(1, 2, 10, 6'h20) | 32'h0000_0040; // R10 nonzero shift
    prog[18] = enc_i(6'h08, 0, 12, -1);
    prog[19] = enc_r(12, 12, 13, 6'h20);       // R2 wraps: fffffffe
    prog[20] = enc_i(6'h08, 0, 14, 0);
    prog[21] = enc_i(6'h08, 0, 15, 3);
    prog[22] = enc_i(6'h08, 14, 14, 1);        // loop body
    prog[23] = enc_i(6'h05, 14, 15, -2);       // R7 backward
    prog[24] = enc_j(28);                      // R8
    prog[25] = enc_i(6'h08, 0, 9, 1);
    prog[28] = enc_i(6'h04, 0, 0, -1);         // self loop
  endtask

  task automatic build_random(input bit [31:0] s, input bit clear_check);
    seed = s;
    for (int i = 0; i < DEPTH; i++) begin
      bit [31:0] r = rnd();
      int k  = int'(r % 10);
      int ra = int'((r >> 4) % 8);
      int rb = int'((r >> 8) % 8);
      int rc = int'((r >> 12) % 8);
      int off = int'((r >> 16) % 9) - 4;
      case (k)
        0: prog[i] = enc_r(ra, rb, rc, 6'h20);
        1: prog[i] = enc_r(ra, rb, rc, 6'h24);
        2: prog[i] = enc_r(ra, rb, rc, 6'h25);
        3: prog[i] = enc_r(ra, rb, rc, 6'h2A);
        4, 5: prog[i] = enc_i(6'h08, ra, rb, int'(r[31:16]) - 32768);
        6: prog[i] = enc_i(6'h04, ra, rb, off);
        7: prog[i] = enc_i(6'h05, ra, rb, off);
        8: prog[i] = enc_j(int'((r >> 20) % DEPTH));
        default: prog[i] = r[0] ? 32'hFC00_0000 : enc_r(ra, rb, rc, 6'h22);
      endcase
    end
    // R1: registers left by the previous program must read as 0
    if (clear_check) prog[0] = enc_r(3, 13, 20, 6'h25);
  endtask

  initial begin
    rst_ni = 1'b0;
    imem_we_i = 1'b0;
    imem_waddr_i = '0;
    imem_wdata_i = '0;
    m_pc = 0;
    build_directed();
    run_prog(80);
    build_random(32'h1234_5678, 1'b1);
    run_prog(500);
    build_random(32'h9E37_79B9, 1'b0);
    run_prog(500);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule